// File: doc/BRIEF.md
# Reloadable Truth-Table Pattern Trigger

This block watches a stream of sampled data words and raises a trigger hit when a word matches a programmable pattern. The word is cut into 4-bit slices. Each slice addresses its own 16-entry, 1-bit truth table, and the table returns a match bit. Because each table holds one bit for every slice value, any Boolean function of four inputs can be matched. Examples are one exact value, a set of values, or a parity condition. The hit is the AND of all slice matches. It is registered and qualified by the sample strobe.

The tables are programmed through a serial port while capture is running. Bits are shifted into a shadow chain, one per clock. A separate commit pulse copies the whole chain into the active tables in one cycle, so the matcher never evaluates a partly loaded pattern. After reset every table holds all ones, so an unconfigured trigger fires on every valid sample.

Top module: `lut_pattern_trigger`

## Requirements
- R1: After reset `trig_hit` is 0, and all tables hold all ones, so the first valid sample of any value gives `trig_hit` = 1 one cycle later.
- R2: When `smp_valid` is 1 at a clock edge and every slice's table returns 1 for that sample, `trig_hit` is 1 after that edge.
- R3: When `smp_valid` is 0 at a clock edge, `trig_hit` is 0 after that edge, whatever the data.
- R4: If any single slice's table returns 0, `trig_hit` is 0 for that sample. Slice k is `smp_data[4k+3:4k]`, and it addresses entry value of slice k of table k.
- R5: The chain shifts toward the top. Each clock with `cfg_shift` = 1 enters `cfg_bit` at chain bit 0. Chain bit 16k+e is entry e of table k. After a full load of NIBBLES*16 bits, the first bit shifted in sits in entry 15 of the highest table, and the last bit shifted in sits in entry 0 of table 0.
- R6: Shifting without a commit leaves the active tables, and therefore the match results, unchanged.
- R7: A `cfg_commit` pulse at a clock edge copies the chain into the active tables. Samples presented at the next edge use the new contents.
- R8: When `cfg_shift` and `cfg_commit` are both 1 at the same edge, the tables receive the chain contents from before that shift, and the chain still shifts.
- R9: A commit does not clear the chain. A second commit with no shifting in between leaves the match results unchanged.
- R10: A table can hold any 4-input function. For example, a table loaded with 0x6996 matches exactly the slice values of odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | NIBBLES*4 | Sampled data word |
| smp_valid | input | 1 | Sample strobe |
| cfg_bit | input | 1 | Serial configuration bit |
| cfg_shift | input | 1 | Shift `cfg_bit` into the chain this clock |
| cfg_commit | input | 1 | Copy the chain into the active tables |
| trig_hit | output | 1 | Registered trigger hit |

## Verification
The bench builds the block with NIBBLES = 2: an 8-bit word and a 32-bit chain. At this size a complete reload takes only 32 shifts, so many images can be loaded in a short run. Every slice value of both tables can also be reached by directed samples. Two slices are enough to show that one failing slice blocks the hit, and that the first shifted bit lands at the highest table's entry 15 rather than at table 0. The shift-and-commit overlap and commit-timing cases are run against a bench model of both the chain and the active tables.

// File: rtl/lut_trig_pkg.sv
package lut_trig_pkg;
    localparam int SLICE_W  = 4;
    localparam int TBL_SIZE = 1 << SLICE_W;

    typedef logic [TBL_SIZE-1:0] tbl_t;
    typedef logic [SLICE_W-1:0]  slice_t;

    typedef enum logic [1:0] {
        CFG_HOLD   = 2'b00,
        CFG_SHIFT  = 2'b01,
        CFG_COMMIT = 2'b10,
        CFG_BOTH   = 2'b11
    } cfg_op_e;

    function automatic logic tbl_lookup(input tbl_t tbl, input slice_t idx);
        return tbl[idx];
    endfunction
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain
    import lut_trig_pkg::*;
#(
    parameter int NIBBLES = 4,
    localparam int CHAIN_W = NIBBLES * TBL_SIZE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               shift_bit,
    output logic [CHAIN_W-1:0] chain
);
    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else if (shift_en)
            chain <= {chain[CHAIN_W-2:0], shift_bit};
    end

    a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain[0] == $past(shift_bit));
    a_r5_shift_up: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain[CHAIN_W-1:1] == $past(chain[CHAIN_W-2:0]));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain));
endmodule

// File: rtl/lut_table_bank.sv
module lut_table_bank
    import lut_trig_pkg::*;
#(
    parameter int NIBBLES = 4,
    localparam int CHAIN_W = NIBBLES * TBL_SIZE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [CHAIN_W-1:0] chain,
    output tbl_t               tables [NIBBLES]
);
    for (genvar k = 0; k < NIBBLES; k++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (rst)
                tables[k] <= '1;
            else if (commit)
                tables[k] <= chain[k*TBL_SIZE +: TBL_SIZE];
        end

        a_r7_copy: assert property (@(posedge clk) disable iff (rst)
            commit |=> tables[k] == $past(chain[k*TBL_SIZE +: TBL_SIZE]));
        a_r6_keep: assert property (@(posedge clk) disable iff (rst)
            !commit |=> $stable(tables[k]));
    end
endmodule

// File: rtl/lut_slice_match.sv
module lut_slice_match
    import lut_trig_pkg::*;
#(
    parameter int NIBBLES = 4,
    localparam int DATA_W = NIBBLES * SLICE_W
) (
    input  tbl_t                tables [NIBBLES],
    input  logic [DATA_W-1:0]   data,
    output logic [NIBBLES-1:0]  slice_ok
);
    for (genvar k = 0; k < NIBBLES; k++) begin : g_slice
        always_comb slice_ok[k] = tbl_lookup(tables[k], data[k*SLICE_W +: SLICE_W]);
    end
endmodule

// File: rtl/lut_pattern_trigger.sv
module lut_pattern_trigger
    import lut_trig_pkg::*;
#(
    parameter int NIBBLES = 4,
    localparam int DATA_W  = NIBBLES * SLICE_W,
    localparam int CHAIN_W = NIBBLES * TBL_SIZE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              cfg_bit,
    input  logic              cfg_shift,
    input  logic              cfg_commit,
    output logic              trig_hit
);
    logic [CHAIN_W-1:0] chain;
    tbl_t               tables [NIBBLES];
    logic [NIBBLES-1:0] slice_ok;
    cfg_op_e            cfg_op;

    assign cfg_op = cfg_op_e'({cfg_commit, cfg_shift});

    lut_cfg_chain #(.NIBBLES(NIBBLES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_op == CFG_SHIFT || cfg_op == CFG_BOTH),
        .shift_bit(cfg_bit),
        .chain    (chain)
    );

    lut_table_bank #(.NIBBLES(NIBBLES)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .commit(cfg_op == CFG_COMMIT || cfg_op == CFG_BOTH),
        .chain (chain),
        .tables(tables)
    );

    lut_slice_match #(.NIBBLES(NIBBLES)) u_match (
        .tables  (tables),
        .data    (smp_data),
        .slice_ok(slice_ok)
    );

    always_ff @(posedge clk) begin
        if (rst)
            trig_hit <= 1'b0;
        else
            trig_hit <= smp_valid && (&slice_ok);
    end

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !trig_hit);
    a_r4_slice_block: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !(&slice_ok)) |=> !trig_hit);
    a_r2_hit_cause: assert property (@(posedge clk) disable iff (rst)
        trig_hit |-> $past(smp_valid));
endmodule

// File: tb/lut_pattern_trigger_bench.sv
module lut_pattern_trigger_bench;
    localparam int NIB = 2;
    localparam int DW  = NIB * 4;
    localparam int CW  = NIB * 16;

    logic          clk = 0;
    logic          rst = 1;
    logic [DW-1:0] smp_data = '0;
    logic          smp_valid = 0;
    logic          cfg_bit = 0;
    logic          cfg_shift = 0;
    logic          cfg_commit = 0;
    logic          trig_hit;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] m_chain;
    logic [CW-1:0] m_active;

    always #10 clk = ~clk;

    lut_pattern_trigger #(.NIBBLES(NIB)) u_lut_pattern_trigger (
        .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
        .cfg_bit(cfg_bit), .cfg_shift(cfg_shift), .cfg_commit(cfg_commit),
        .trig_hit(trig_hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [DW-1:0] d);
        return m_active[16 + d[7:4]] && m_active[d[3:0]];
    endfunction

    // present one sample; result sampled one cycle later at negedge
    task automatic sample(input string req, input logic [DW-1:0] d, input logic v);
        smp_data = d; smp_valid = v;
        @(negedge clk);
        smp_valid = 0;
        check(req, trig_hit, v && model_hit(d));
    endtask

    task automatic cfg_cycle(input logic b, input logic sh, input logic cm);
        cfg_bit = b; cfg_shift = sh; cfg_commit = cm;
        @(negedge clk);
        if (cm) m_active = m_chain;
        if (sh) m_chain = {m_chain[CW-2:0], b};
        cfg_shift = 0; cfg_commit = 0;
    endtask

    task automatic shift_image(input logic [CW-1:0] img);
        for (int i = CW - 1; i >= 0; i--) cfg_cycle(img[i], 1'b1, 1'b0);
    endtask

    task automatic load(input logic [CW-1:0] img);
        shift_image(img);
        cfg_cycle(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset;
        m_chain = '1; m_active = '1;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1", trig_hit, 1'b0);
        sample("R1", 8'h3C, 1'b1);
        sample("R1", 8'h00, 1'b1);
    endtask

    task automatic t_idle;
        sample("R3", 8'hFF, 1'b0);
        sample("R3", 8'h12, 1'b0);
    endtask

    task automatic t_exact;
        logic [CW-1:0] img = '0;
        img[16 + 4'hA] = 1'b1;
        img[4'h5] = 1'b1;
        load(img);
        sample("R2", 8'hA5, 1'b1);
        sample("R4", 8'hA4, 1'b1);
        sample("R4", 8'hB5, 1'b1);
        sample("R3", 8'hA5, 1'b0);
    endtask

    task automatic t_order;
        logic [CW-1:0] img = '0;
        img[CW-1] = 1'b1;
        img[0] = 1'b1;
        load(img);
        sample("R5", 8'hF0, 1'b1);
        check("R5", model_hit(8'hF0), 1'b1);
        sample("R5", 8'h0F, 1'b1);
        sample("R5", 8'h00, 1'b1);
    endtask

    task automatic t_no_commit;
        shift_image('0);
        sample("R6", 8'hF0, 1'b1);
        check("R6", model_hit(8'hF0), 1'b1);
        cfg_cycle(1'b0, 1'b0, 1'b1);
        sample("R7", 8'hF0, 1'b1);
        shift_image('1);
        cfg_commit = 1;
        @(negedge clk);
        cfg_commit = 0;
        m_active = m_chain;
        sample("R7", 8'h81, 1'b1);
    endtask

    task automatic t_overlap;
        logic [CW-1:0] img = '1;
        img[3] = 1'b0;
        shift_image(img);
        cfg_cycle(1'b1, 1'b1, 1'b1);
        sample("R8", 8'h03, 1'b1);
        sample("R8", 8'h04, 1'b1);
        cfg_cycle(1'b0, 1'b0, 1'b1);
        sample("R8", 8'h04, 1'b1);
        sample("R8", 8'h03, 1'b1);
        cfg_cycle(1'b0, 1'b0, 1'b1);
        sample("R9", 8'h04, 1'b1);
        sample("R9", 8'h03, 1'b1);
    endtask

    task automatic t_parity;
        load({16'hFFFF, 16'h6996});
        for (int v = 0; v < 16; v++) begin
            sample("R10", {4'h7, 4'(v)}, 1'b1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_idle;
        t_exact;
        t_order;
        t_no_commit;
        t_overlap;
        t_parity;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule